// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous memory. Each word is 36 bits wide and is split into four 9-bit byte lanes. Address, direction, lane write enables and chip selects are registered on a rising clock edge. The data phase for that command happens on the second enabled clock edge after it, for reads and for writes alike. Write data is therefore taken two edges after the write command, which is the same delay as read data. A read may follow a write, or a write a read, in the very next cycle with no idle slot on the data bus.

An active-low clock enable freezes the whole block, including commands in flight. Three chip selects let the block be left out of a cycle. A deselect only stops new work; commands already in the pipeline still complete. The data bus is modelled as separate input, output and output-valid signals. An asynchronous output enable gates the output-valid signal. Burst address generation belongs to a separate sequencer that presents a fresh address on every load.

Top module: `zbt_sram`

## Requirements
- R1: A read command is issued when `load_n`, `ce_a_n` and `ce_b_n` are low, `ce_c` is high and `wr_n` is high at an enabled edge. After the second enabled edge following it, `rdata` holds the word at `addr` and `rdata_oe` is high while `oe_n` is low.
- R2: For a write command (`wr_n` low), `wdata` is sampled on the second enabled edge after the command. Lane i, which is bits [9i+8:9i], is written only when `bw_n[i]` is 0. Lanes whose `bw_n` bit is 1 keep their old contents.
- R3: `bw_n` has no effect on a read command: the memory is unchanged by it.
- R4: While `cke_n` is high at an edge, that edge is ignored. Commands in flight, the stored data, `rdata` and `rdata_oe` all hold. No write data is taken on that edge.
- R5: When `load_n` is low and any chip select is inactive (`ce_a_n` high, `ce_b_n` high or `ce_c` low), no operation is started. `rdata_oe` is low after the second enabled edge following it.
- R6: Reads and writes issued before a deselect still complete with their normal timing.
- R7: After the second enabled edge following a write command, `rdata_oe` is low. Reads and writes may alternate every cycle, and every read still delivers its data.
- R8: While `oe_n` is high, `rdata_oe` is low at once, with no clock edge needed. The pipeline is unaffected, so a pending read shows its data once `oe_n` returns low.
- R9: When `load_n` is high, no operation is started and `addr`, `wr_n` and `bw_n` are ignored.
- R10: A read of an address that was written by an earlier command, including one issued one or two cycles before it, returns the newly written lanes merged with the unwritten old lanes.
- R11: After a cycle with `rst_n` low, `rdata_oe` is low and no command is in flight. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| cke_n | input | 1 | Active-low clock enable; high stalls the block |
| load_n | input | 1 | Active-low load of a new command |
| ce_a_n | input | 1 | Active-low chip select |
| ce_b_n | input | 1 | Active-low chip select |
| ce_c | input | 1 | Active-high chip select |
| wr_n | input | 1 | Direction: 0 write, 1 read |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Active-low lane write enables |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data |
| rdata_oe | output | 1 | High when `rdata` would drive the bus |

## Verification
The bench targets several corner cases, and each one shows a specific fault. A read issued right after a write to the same address catches a write that lands late or that takes data from the wrong cycle; the read would return stale lanes. Partial lane masks followed by full reads expose lanes that are written when they should be kept, or the reverse. Stall bursts in the middle of traffic, with garbage on the write data bus, show whether a design advances one pipeline stage or captures data on a frozen edge. Deselects directly behind reads and writes, toggles of `oe_n`, and cycles with `load_n` high catch three more faults: a deselect that flushes pending work, an output enable that clobbers pipeline state, and an ignored address that starts an operation anyway.

// File: rtl/zbt_pkg.sv
// Shared definitions for the zero-turnaround SRAM.
// Assumes: one command per cycle, with its direction encoded as below.
package zbt_pkg;
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;
endpackage

// File: rtl/zbt_cmd_stage.sv
// One register stage of the command pipeline. It carries valid, direction,
// address and lane enables. Assumes en is the stall-gated clock enable; the
// stage holds when en is low.
module zbt_cmd_stage
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              d_vld,
    input  op_e               d_op,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [LANES-1:0]  d_bw_n,
    output logic              q_vld,
    output op_e               q_op,
    output logic [ADDR_W-1:0] q_addr,
    output logic [LANES-1:0]  q_bw_n
);
    // Valid bit: cleared by reset, advanced on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)  q_vld <= 1'b0;
        else if (en) q_vld <= d_vld;
    end

    // Command payload: advanced on enabled edges; needs no reset.
    always_ff @(posedge clk) begin
        if (en) begin
            q_op   <= d_op;
            q_addr <= d_addr;
            q_bw_n <= d_bw_n;
        end
    end

    assert_stage_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q_vld == $past(d_vld)));
    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(q_vld) && $stable(q_addr) && $stable(q_op)));
endmodule

// File: rtl/zbt_lane_array.sv
// Storage and data phase. Each byte lane has its own memory. A write merges
// wdata into the enabled lanes. A read registers the word and raises out_en.
// Assumes at most one data-phase command per edge.
module zbt_lane_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     vld,
    input  op_e                      op,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         bw_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     out_en
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // Lane access: write when enabled by its mask bit, read on read commands.
        always_ff @(posedge clk) begin
            if (en && vld) begin
                if (op == OP_WR) begin
                    if (!bw_n[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
                end else begin
                    rd_q <= store[addr];
                end
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

    // Output-valid flag: set only by a completing read, held during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)  out_en <= 1'b0;
        else if (en) out_en <= vld && (op == OP_RD);
    end

    assert_write_releases_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vld && op == OP_WR) |=> !out_en);
    assert_read_drives_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && vld && op == OP_RD) |=> out_en);
    assert_stall_holds_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(out_en) && $stable(rdata)));
endmodule

// File: rtl/zbt_sram.sv
// Top level of the zero-turnaround pipelined SRAM. It decodes chip selects
// and load, runs a two-stage command pipeline, and executes the data phase
// on the second enabled edge. The asynchronous output enable gates rdata_oe.
// Assumes addresses for bursts come from an external sequencer.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     load_n,
    input  logic                     ce_a_n,
    input  logic                     ce_b_n,
    input  logic                     ce_c,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         bw_n,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic                     oe_n,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_oe
);
    localparam int WORD_W = LANES * LANE_W;

    logic              step;
    logic              selected;
    logic              issue;
    op_e               cmd_op;
    logic              s1_vld, s2_vld;
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_bw_n, s2_bw_n;
    logic              out_en;
    logic [WORD_W-1:0] rd_word;

    // Command decode: chip selects and load qualify a new command.
    always_comb begin
        step     = !cke_n;
        selected = !ce_a_n && !ce_b_n && ce_c;
        issue    = !load_n && selected;
        cmd_op   = wr_n ? OP_RD : OP_WR;
    end

    zbt_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .en(step),
        .d_vld(issue), .d_op(cmd_op), .d_addr(addr), .d_bw_n(bw_n),
        .q_vld(s1_vld), .q_op(s1_op), .q_addr(s1_addr), .q_bw_n(s1_bw_n)
    );

    zbt_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .en(step),
        .d_vld(s1_vld), .d_op(s1_op), .d_addr(s1_addr), .d_bw_n(s1_bw_n),
        .q_vld(s2_vld), .q_op(s2_op), .q_addr(s2_addr), .q_bw_n(s2_bw_n)
    );

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .en(step),
        .vld(s2_vld), .op(s2_op), .addr(s2_addr), .bw_n(s2_bw_n),
        .wdata(wdata), .rdata(rd_word), .out_en(out_en)
    );

    // Bus gating: asynchronous output enable over the registered valid flag.
    always_comb begin
        rdata    = rd_word;
        rdata_oe = out_en && !oe_n;
    end

    assert_deselect_no_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !load_n && (ce_a_n || ce_b_n || !ce_c)) |=> !s1_vld);
    assert_advance_no_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && load_n) |=> !s1_vld);
    assert_pending_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_vld) |=> s2_vld);
    assert_reset_empty_R11: assert property (@(posedge clk)
        !rst_n |=> (!s1_vld && !s2_vld && !rdata_oe));
endmodule

// File: tb/zbt_sram_tb.sv
// Self-checking bench for zbt_sram: directed corner cases plus seeded random
// traffic, compared each cycle against a behavioural shadow model.
module zbt_sram_tb_top;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int WW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          load_n = 1'b1;
    logic          ce_a_n = 1'b0;
    logic          ce_b_n = 1'b0;
    logic          ce_c = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw_n = '1;
    logic [WW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [WW-1:0] rdata;
    logic          rdata_oe;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n),
        .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c), .wr_n(wr_n),
        .addr(addr), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R11";
    bit    done = 1'b0;

    // Shadow model state.
    logic [WW-1:0] shadow [DEPTH];
    logic          m1_v = 1'b0, m2_v = 1'b0, m_oe = 1'b0;
    logic          m1_w, m2_w;
    logic [AW-1:0] m1_a, m2_a;
    logic [NL-1:0] m1_b, m2_b;
    logic [WW-1:0] m_rd = '0;

    function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                            input logic [WW-1:0] new_w,
                                            input logic [NL-1:0] mask_n);
        logic [WW-1:0] r = old_w;
        for (int i = 0; i < NL; i++)
            if (!mask_n[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    // Model update after each rising edge, from the inputs that were sampled.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            m1_v = 1'b0; m2_v = 1'b0; m_oe = 1'b0;
        end else if (!cke_n) begin
            if (m2_v && m2_w) shadow[m2_a] = merge(shadow[m2_a], wdata, m2_b);
            if (m2_v && !m2_w) m_rd = shadow[m2_a];
            m_oe = m2_v && !m2_w;
            m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_b = m1_b;
            m1_v = !load_n && !ce_a_n && !ce_b_n && ce_c;
            m1_w = !wr_n; m1_a = addr; m1_b = bw_n;
        end
    end

    task automatic check_outputs();
        logic exp_oe = m_oe && !oe_n;
        n_chk++;
        if (rdata_oe !== exp_oe) begin
            n_bad++;
            $display("FAIL %s: rdata_oe actual %b expected %b at %0t", tag, rdata_oe, exp_oe, $time);
        end
        if (m_oe) begin
            n_chk++;
            if (rdata !== m_rd) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h at %0t", tag, rdata, m_rd, $time);
            end
        end
    endtask

    // One cycle: check the outputs of the previous edge, then drive new inputs.
    task automatic cyc(input logic st, input logic ld, input logic [2:0] ce,
                       input logic w, input logic [AW-1:0] a,
                       input logic [NL-1:0] b, input logic [WW-1:0] d, input logic oe);
        @(negedge clk);
        if (rst_n) check_outputs();
        cke_n = st; load_n = ld; ce_a_n = ce[2]; ce_b_n = ce[1]; ce_c = ce[0];
        wr_n = w; addr = a; bw_n = b; wdata = d; oe_n = oe;
    endtask

    function automatic logic [WW-1:0] rnd_word();
        return {$urandom(), $urandom()};
    endfunction

    localparam logic [2:0] SEL = 3'b001;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: outputs quiet while and right after reset.
        n_chk++;
        if (rdata_oe !== 1'b0) begin
            n_bad++; $display("FAIL R11: rdata_oe actual %b expected 0", rdata_oe);
        end
        rst_n = 1'b1;
        tag = "R11";
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);

        // R2: fill every word with full-lane writes (data follows two cycles later).
        tag = "R2";
        for (int i = 0; i < DEPTH + 2; i++)
            cyc(0, (i >= DEPTH), SEL, 0, AW'(i), '0, rnd_word(), 0);

        // R1: plain reads.
        tag = "R1";
        for (int i = 0; i < 6; i++) cyc(0, 0, SEL, 1, AW'(i), '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R10/R7: partial write then read of same address next cycle and two later.
        tag = "R10";
        cyc(0, 0, SEL, 0, 6'd9, 4'b1010, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd9, '1, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd9, '1, rnd_word(), 0);
        cyc(0, 0, SEL, 0, 6'd10, 4'b0110, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd10, 4'b0000, rnd_word(), 0);
        tag = "R7";
        for (int i = 0; i < 8; i++) cyc(0, 0, SEL, i[0], AW'(i + 12), 4'b0000, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R3: read with all lane enables active leaves memory untouched.
        tag = "R3";
        cyc(0, 0, SEL, 1, 6'd20, 4'b0000, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd20, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R4: stall in mid-flight with garbage inputs.
        tag = "R4";
        cyc(0, 0, SEL, 0, 6'd21, 4'b1100, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd22, '1, rnd_word(), 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, SEL, 0, AW'($urandom()), 4'b0000, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd21, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);
        cyc(1, 1, SEL, 1, '0, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R5/R6: deselects (each chip select in turn) right behind pending work.
        tag = "R6";
        cyc(0, 0, SEL, 1, 6'd3, '1, rnd_word(), 0);
        cyc(0, 0, SEL, 0, 6'd4, 4'b0101, rnd_word(), 0);
        tag = "R5";
        cyc(0, 0, 3'b101, 1, 6'd5, '1, rnd_word(), 0);
        cyc(0, 0, 3'b011, 0, 6'd6, 4'b0000, rnd_word(), 0);
        cyc(0, 0, 3'b000, 0, 6'd7, 4'b0000, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd4, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R9: load_n high ignores address, direction and lane enables.
        tag = "R9";
        for (int i = 0; i < 3; i++) cyc(0, 1, SEL, 0, AW'(i + 30), 4'b0000, rnd_word(), 0);
        cyc(0, 0, SEL, 1, 6'd30, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R8: oe_n high masks a pending read, which reappears once it drops.
        tag = "R8";
        cyc(0, 0, SEL, 1, 6'd31, '1, rnd_word(), 1);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 1);
        cyc(1, 1, SEL, 1, '0, '1, rnd_word(), 1);
        cyc(1, 1, SEL, 1, '0, '1, rnd_word(), 0);
        cyc(0, 1, SEL, 1, '0, '1, rnd_word(), 0);

        // R1/R2 with everything mixed: random traffic.
        tag = "R1 random";
        for (int i = 0; i < 3000; i++)
            cyc(($urandom() % 8) == 0, ($urandom() % 6) == 0,
                (($urandom() % 10) == 0) ? 3'($urandom()) : SEL,
                $urandom() % 2, AW'($urandom()), NL'($urandom()), rnd_word(),
                ($urandom() % 12) == 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);

        // R11: reset mid-traffic empties the pipeline.
        tag = "R11";
        cyc(0, 0, SEL, 1, 6'd1, '1, '0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        load_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);
        cyc(0, 1, SEL, 1, '0, '1, '0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule